// File: doc/BRIEF.md
# Multi-mode incremental pulse counter

This block counts pulses from an incremental sensor or a pulse source into a signed or unsigned count register. Three asynchronous inputs, A, B and Z, are first brought into the clock domain. The block then turns their edges into count steps using one of four schemes, chosen by a mode select: 4x quadrature on A and B; up pulses on A and down pulses on B; count pulses on A with the direction taken from the level of B; and up-only pulses on A. Z always serves as the hardware clear input.

The count runs in one of two ranges. In linear mode it is a two's-complement value that saturates at its extremes and raises sticky overflow or underflow flags. In ring mode it stays within zero and a programmable maximum and wraps at both ends. A clear-method select and a software clear bit set when the count returns to zero. Each clear gives a one-cycle strobe. All control pins are plain levels sampled on the clock. The block has no streaming data path, so it has no valid/ready handshake and no back-pressure.

Top module: `pcnt_top`

## Requirements
- R1: A, B and Z each pass through a two-flop synchroniser. An A rising edge that is driven between two clock edges changes `count` at the third rising clock edge after it, and not earlier. With no count step and no clear, `count` holds its value.
- R2: With `mode`=0 (quadrature), every single-phase change of A or B is one step, which gives 4x resolution. The count goes up through the phase sequence {A,B} = 00→10→11→01→00 and goes down through the reverse sequence.
- R3: In quadrature mode, a transition in which A and B change in the same cycle does not move the count. It sets the sticky `quad_err` output, which stays high until the next clear event.
- R4: With `mode`=1, a rising edge on A adds one and a rising edge on B subtracts one. When both rising edges arrive in the same cycle, they cancel and the count is unchanged.
- R5: With `mode`=2, each rising edge on A is one step. It counts up when B is low and down when B is high. Changes of B alone never step the count.
- R6: With `mode`=3, each rising edge on A adds one. B has no effect, and neither do falling edges on A.
- R7: With `ring_en`=0, the count is a signed CNT_W-bit value. An up step at the largest positive value leaves the count there and sets sticky `ovf`. A down step at the most negative value leaves the count there and sets sticky `unf`. Both flags clear only on a clear event or on `rst_n`.
- R8: With `ring_en`=1, an up step at or above the ring maximum goes to 0. A down step at 0 goes to the ring maximum. The ring maximum is `ring_max`, and a value of 0 is treated as 1. Ring wraps do not set `ovf` or `unf`.
- R9: With `rst_sel`=0, the count clears when Z rises while `sw_rst` is already high. Z with `sw_rst` low, and any `sw_rst` change without Z, leave the count unchanged. With `rst_sel`=1, Z has no effect.
- R10: With `rst_sel`=1, the count clears on the clock after `sw_rst` rises. Holding `sw_rst` high gives no further clears, and counting continues while it is held.
- R11: A clear event forces `count` to 0. It also zeroes `ovf`, `unf` and `quad_err`, and wins over a count step in the same cycle. `rst_evt` is high for exactly the one cycle in which the cleared count first shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_a | input | 1 | Phase A / up pulse / count pulse (asynchronous) |
| in_b | input | 1 | Phase B / down pulse / direction level (asynchronous) |
| in_z | input | 1 | Hardware clear input (asynchronous) |
| mode | input | 2 | Decode scheme: 0 quadrature, 1 up/down, 2 pulse+direction, 3 up only |
| ring_en | input | 1 | 0 linear signed range, 1 ring range |
| ring_max | input | CNT_W | Ring maximum (0 treated as 1) |
| rst_sel | input | 1 | Clear method: 0 Z gated by software bit, 1 software bit edge |
| sw_rst | input | 1 | Software clear bit |
| count | output | CNT_W | Present count value |
| rst_evt | output | 1 | One-cycle strobe on each clear |
| ovf | output | 1 | Sticky linear overflow flag |
| unf | output | 1 | Sticky linear underflow flag |
| quad_err | output | 1 | Sticky illegal quadrature transition flag |

## Verification
The bench drives the linear count into both signed limits. A design that wrapped there instead of saturating, or that set the wrong flag, would show a jump across the sign boundary. It runs the ring through both of its wrap points and through the zero-maximum case, where an off-by-one at the wrap compare or an unguarded zero would show as a wrong value or a count stuck at zero. It also tests simultaneous up/down pulses, a two-phase quadrature jump, and a clear that lands in the same cycle as a step. A design that got these wrong would be off by one count or would keep a stale error flag. Each clear method gets both its firing stimulus and its non-firing stimuli, so that a wrongly gated clear would show as a count that drops to zero when it should not.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  typedef enum logic [1:0] {
    DEC_QUAD = 2'd0,
    DEC_UPDN = 2'd1,
    DEC_PDIR = 2'd2,
    DEC_INC  = 2'd3
  } dec_mode_e;

  typedef enum logic {
    CLR_Z_AND_SW = 1'b0,
    CLR_SW_EDGE  = 1'b1
  } clr_sel_e;

  typedef struct packed {
    logic up;
    logic dn;
  } step_t;
endpackage

// File: rtl/pcnt_sync.sv
module pcnt_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pcnt_decode.sv
module pcnt_decode
  import pcnt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      a,
  input  logic      b,
  input  logic      z,
  input  dec_mode_e mode,
  output step_t     step,
  output logic      z_rise,
  output logic      dbl_flip
);
  logic a_q, b_q, z_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
      z_q <= 1'b0;
    end else begin
      a_q <= a;
      b_q <= b;
      z_q <= z;
    end
  end

  logic a_chg, b_chg, a_rise, b_rise;
  assign a_chg  = a ^ a_q;
  assign b_chg  = b ^ b_q;
  assign a_rise = a & ~a_q;
  assign b_rise = b & ~b_q;
  assign z_rise = z & ~z_q;

  always_comb begin
    step     = '0;
    dbl_flip = 1'b0;
    unique case (mode)
      DEC_QUAD: begin
        if (a_chg && b_chg) begin
          dbl_flip = 1'b1;
        end else if (a_chg) begin
          step.up = (a != b);
          step.dn = (a == b);
        end else if (b_chg) begin
          step.up = (a == b);
          step.dn = (a != b);
        end
      end
      DEC_UPDN: begin
        step.up = a_rise & ~b_rise;
        step.dn = b_rise & ~a_rise;
      end
      DEC_PDIR: begin
        step.up = a_rise & ~b;
        step.dn = a_rise & b;
      end
      DEC_INC: begin
        step.up = a_rise;
      end
      default: step = '0;
    endcase
  end
endmodule

// File: rtl/pcnt_core.sv
module pcnt_core
  import pcnt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  step_t            step,
  input  logic             clear,
  input  logic             qerr_in,
  input  logic             ring_en,
  input  logic [CNT_W-1:0] ring_max,
  output logic [CNT_W-1:0] count,
  output logic             rst_evt,
  output logic             ovf,
  output logic             unf,
  output logic             quad_err
);
  localparam logic [CNT_W-1:0] LIN_MAX = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] LIN_MIN = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] rmax, cnt_nx;
  logic             ovf_nx, unf_nx, qerr_nx;

  assign rmax = (ring_max == '0) ? ONE : ring_max;

  always_comb begin
    cnt_nx  = count;
    ovf_nx  = ovf;
    unf_nx  = unf;
    qerr_nx = quad_err | qerr_in;
    if (clear) begin
      cnt_nx  = '0;
      ovf_nx  = 1'b0;
      unf_nx  = 1'b0;
      qerr_nx = 1'b0;
    end else if (step.up) begin
      if (ring_en) cnt_nx = (count >= rmax) ? '0 : count + ONE;
      else if (count == LIN_MAX) ovf_nx = 1'b1;
      else cnt_nx = count + ONE;
    end else if (step.dn) begin
      if (ring_en) cnt_nx = (count == '0 || count > rmax) ? rmax : count - ONE;
      else if (count == LIN_MIN) unf_nx = 1'b1;
      else cnt_nx = count - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      ovf      <= 1'b0;
      unf      <= 1'b0;
      quad_err <= 1'b0;
      rst_evt  <= 1'b0;
    end else begin
      count    <= cnt_nx;
      ovf      <= ovf_nx;
      unf      <= unf_nx;
      quad_err <= qerr_nx;
      rst_evt  <= clear;
    end
  end
endmodule

// File: rtl/pcnt_top.sv
module pcnt_top
  import pcnt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_a,
  input  logic             in_b,
  input  logic             in_z,
  input  logic [1:0]       mode,
  input  logic             ring_en,
  input  logic [CNT_W-1:0] ring_max,
  input  logic             rst_sel,
  input  logic             sw_rst,
  output logic [CNT_W-1:0] count,
  output logic             rst_evt,
  output logic             ovf,
  output logic             unf,
  output logic             quad_err
);
  logic [2:0] raw_in, syn_in;
  step_t      step;
  logic       step_up, step_dn;
  logic       z_rise, dbl_flip, sw_q, sw_rise, clr_req;

  assign raw_in = {in_z, in_b, in_a};

  pcnt_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  pcnt_decode u_dec (
    .clk(clk), .rst_n(rst_n),
    .a(syn_in[0]), .b(syn_in[1]), .z(syn_in[2]),
    .mode(dec_mode_e'(mode)),
    .step(step), .z_rise(z_rise), .dbl_flip(dbl_flip)
  );

  assign step_up = step.up;
  assign step_dn = step.dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_q <= 1'b0;
    else        sw_q <= sw_rst;
  end
  assign sw_rise = sw_rst & ~sw_q;

  always_comb begin
    if (clr_sel_e'(rst_sel) == CLR_SW_EDGE) clr_req = sw_rise;
    else                                    clr_req = z_rise & sw_rst;
  end

  pcnt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .step(step), .clear(clr_req),
    .qerr_in(dbl_flip), .ring_en(ring_en), .ring_max(ring_max),
    .count(count), .rst_evt(rst_evt), .ovf(ovf), .unf(unf),
    .quad_err(quad_err)
  );
endmodule

// File: rtl/pcnt_checker.sv
module pcnt_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count,
  input logic             rst_evt,
  input logic             ovf,
  input logic             ring_en,
  input logic [CNT_W-1:0] ring_max,
  input logic             step_up,
  input logic             step_dn,
  input logic             clear
);
  localparam logic [CNT_W-1:0] LMAX = {1'b0, {(CNT_W-1){1'b1}}};
  logic [CNT_W-1:0] eff_max;
  assign eff_max = (ring_max == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : ring_max;

  assert_clear_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |-> (count == '0));

  assert_step_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_dn));

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_up && !step_dn && !clear) |=> $stable(count));

  assert_ring_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_en && (step_up || step_dn) && !clear) |=> (count <= $past(eff_max)));

  assert_sat_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ring_en && step_up && !clear && count == LMAX) |=> (count == LMAX && ovf));

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clear) |=> ovf);
endmodule

bind pcnt_top pcnt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .count(count), .rst_evt(rst_evt), .ovf(ovf),
  .ring_en(ring_en), .ring_max(ring_max), .step_up(step_up),
  .step_dn(step_dn), .clear(clr_req)
);

// File: tb/pcnt_top_test.sv
`timescale 1ns/1ps
module pcnt_top_test;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_a = 0, in_b = 0, in_z = 0, ring_en = 0, rst_sel = 1, sw_rst = 0;
  logic [1:0] mode = 2'd3;
  logic [W-1:0] ring_max = '0;
  logic [W-1:0] count;
  logic rst_evt, ovf, unf, quad_err;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [W-1:0] exp_c;

  always #5 clk = ~clk;

  pcnt_top #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .in_z(in_z),
    .mode(mode), .ring_en(ring_en), .ring_max(ring_max), .rst_sel(rst_sel),
    .sw_rst(sw_rst), .count(count), .rst_evt(rst_evt), .ovf(ovf), .unf(unf),
    .quad_err(quad_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_a();
    @(negedge clk) in_a = 1;
    repeat (2) @(negedge clk);
    in_a = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_b();
    @(negedge clk) in_b = 1;
    repeat (2) @(negedge clk);
    in_b = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sw_clear();
    @(negedge clk);
    rst_sel = 1; sw_rst = 0;
    @(negedge clk) sw_rst = 1;
    @(negedge clk) sw_rst = 0;
    settle();
  endtask

  task automatic t_reset();
    chk("reset count", count, 0);
    chk("reset flags", {ovf, unf, quad_err, rst_evt}, 0);
  endtask

  task automatic t_latency_R1();
    mode = 2'd3;
    @(negedge clk) in_a = 1;
    repeat (2) @(negedge clk);
    chk("R1 no change after two edges", count, 0);
    @(negedge clk);
    chk("R1 change at third edge", count, 1);
    in_a = 0;
    settle();
    chk("R1 hold when idle", count, 1);
  endtask

  task automatic t_inc_R6();
    mode = 2'd3;
    pulse_b(); pulse_b(); settle();
    chk("R6 B ignored", count, 1);
    pulse_a(); pulse_a(); pulse_a(); settle();
    chk("R6 A rising counts", count, 4);
  endtask

  task automatic quad_to(input logic a, input logic b);
    @(negedge clk); in_a = a; in_b = b;
    settle();
  endtask

  task automatic t_quad_R2_R3();
    sw_clear();
    mode = 2'd0;
    quad_to(1, 0); quad_to(1, 1); quad_to(0, 1); quad_to(0, 0);
    chk("R2 forward 4x", count, 4);
    quad_to(0, 1); quad_to(1, 1);
    chk("R2 reverse", count, 2);
    chk("R3 no error yet", quad_err, 0);
    quad_to(0, 0);
    chk("R3 double flip ignored", count, 2);
    chk("R3 error raised", quad_err, 1);
    quad_to(1, 0); quad_to(0, 0);
    chk("R3 error sticky", quad_err, 1);
    sw_clear();
    chk("R3 error cleared by clear", quad_err, 0);
    mode = 2'd3;
  endtask

  task automatic t_updn_R4();
    sw_clear();
    mode = 2'd1;
    pulse_a(); pulse_a(); pulse_a(); pulse_b(); settle();
    chk("R4 up/down net", count, 2);
    @(negedge clk); in_a = 1; in_b = 1;
    repeat (2) @(negedge clk);
    in_a = 0; in_b = 0;
    settle();
    chk("R4 simultaneous cancel", count, 2);
  endtask

  task automatic t_pdir_R5();
    sw_clear();
    mode = 2'd2;
    pulse_a(); pulse_a(); settle();
    chk("R5 B low counts up", count, 2);
    @(negedge clk) in_b = 1;
    settle();
    chk("R5 B change alone ignored", count, 2);
    pulse_a(); pulse_a(); pulse_a(); settle();
    chk("R5 B high counts down", count, 8'hFF);
    @(negedge clk) in_b = 0;
    settle();
  endtask

  task automatic t_linear_R7();
    sw_clear();
    mode = 2'd1; ring_en = 0;
    pulse_b(); settle();
    chk("R7 signed below zero", count, 8'hFF);
    chk("R7 no flag at -1", unf, 0);
    sw_clear();
    for (int i = 0; i < 127; i++) pulse_a();
    settle();
    chk("R7 reach max", count, 8'h7F);
    chk("R7 no ovf at max", ovf, 0);
    pulse_a(); pulse_a(); settle();
    chk("R7 saturate high", count, 8'h7F);
    chk("R7 ovf set", ovf, 1);
    pulse_b(); settle();
    chk("R7 ovf sticky", {ovf, count}, {1'b1, 8'h7E});
    sw_clear();
    chk("R7 ovf cleared", ovf, 0);
    for (int i = 0; i < 130; i++) pulse_b();
    settle();
    chk("R7 saturate low", count, 8'h80);
    chk("R7 unf set", {unf, ovf}, 2'b10);
    sw_clear();
    chk("R7 unf cleared", unf, 0);
  endtask

  task automatic t_ring_R8();
    mode = 2'd1; ring_en = 1; ring_max = 8'd5;
    pulse_b(); settle();
    chk("R8 down from 0 wraps to max", count, 5);
    pulse_a(); settle();
    chk("R8 up from max wraps to 0", count, 0);
    chk("R8 wrap sets no flag", {ovf, unf}, 0);
    ring_max = 8'd0;
    pulse_a(); settle();
    chk("R8 zero max as one: step", count, 1);
    pulse_a(); settle();
    chk("R8 zero max as one: wrap", count, 0);
    ring_en = 0; ring_max = 8'd5;
  endtask

  task automatic t_zclear_R9();
    sw_clear();
    mode = 2'd3;
    pulse_a(); pulse_a(); settle();
    @(negedge clk); rst_sel = 0; sw_rst = 1;
    settle();
    chk("R9 sw bit alone no clear", count, 2);
    @(negedge clk) in_z = 1;
    settle();
    chk("R9 Z with bit clears", count, 0);
    in_z = 0; sw_rst = 0;
    pulse_a(); settle();
    @(negedge clk) in_z = 1;
    settle();
    in_z = 0;
    settle();
    chk("R9 Z without bit ignored", count, 1);
    @(negedge clk) rst_sel = 1;
    @(negedge clk) in_z = 1;
    settle();
    in_z = 0;
    settle();
    chk("R9 Z ignored in sw method", count, 1);
  endtask

  task automatic t_swclear_R10_R11();
    rst_sel = 1;
    pulse_a(); settle();
    exp_c = 2;
    chk("R10 count before clear", count, exp_c);
    @(negedge clk) sw_rst = 1;
    @(negedge clk);
    chk("R11 strobe with zero", {rst_evt, count}, {1'b1, 8'h00});
    @(negedge clk);
    chk("R11 strobe one cycle", rst_evt, 0);
    pulse_a(); pulse_a(); settle();
    chk("R10 held bit: counting resumes", count, 2);
    @(negedge clk) sw_rst = 0;
    settle();
    @(negedge clk) in_a = 1;
    repeat (2) @(posedge clk);
    @(negedge clk) sw_rst = 1;
    @(negedge clk);
    chk("R11 clear beats step", count, 0);
    chk("R11 strobe on clash", rst_evt, 1);
    sw_rst = 0; in_a = 0;
    settle();
    chk("R11 no late step", count, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_latency_R1();
    t_inc_R6();
    t_quad_R2_R3();
    t_updn_R4();
    t_pdir_R5();
    t_linear_R7();
    t_ring_R8();
    t_zclear_R9();
    t_swclear_R10_R11();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule